// File: doc/BRIEF.md
# Video Frame CRC Checker

This block watches a 24-bit parallel RGB pixel stream on its own pixel clock. It runs a CRC32 over each frame as the frame arrives. At every frame boundary it compares the finished checksum against a reference value that software has programmed. Frames whose checksum matches add to a good counter. Frames whose checksum differs add to a corrupted counter. A test bench for a display output places one instance on each video output. It loads the expected checksum, enables checking, lets video run for a few seconds, then disables checking and reads both counters.

Each clock with the data-enable strobe high carries one pixel, and all three bytes of that pixel are folded into the checksum in that same cycle. A full-HD stream at 60 frames per second therefore needs a pixel clock no faster than the stream's own. The rising edge of vertical sync closes one frame and opens the next. A small word-addressed register port gives access to control, the reference value, both counters and the most recent frame checksum. Software can read that last checksum to capture a golden value from a known-good source.

Top module: `vfcrc_checker`

## Requirements
- R1: The checksum is the reflected CRC32 (polynomial 0x04C11DB7, processed as 0xEDB88320 shifting right), preset to 0xFFFFFFFF at every frame boundary, with the final value inverted. Each pixel contributes three bytes, R (`pix_data[23:16]`) first, then G (`[15:8]`), then B (`[7:0]`). A frame whose bytes spell the ASCII string "123456789" yields 0xCBF43926.
- R2: At a frame boundary, when the finished checksum equals the reference register (address 1), the good counter (address 2) increments by one.
- R3: At a frame boundary, when the finished checksum differs from the reference, the corrupted counter (address 3) increments by one and the good counter does not change.
- R4: After checking is enabled, the first vertical-sync rising edge only arms the checker. Pixels received before that edge are not counted, and the last-checksum register is not updated.
- R5: A frame boundary with no data-enable pixel since the previous boundary changes neither counter nor the last-checksum register.
- R6: While the enable bit (address 0, bit 0) is 0, pixels and vertical sync change neither counter nor the last-checksum register.
- R7: Writing 1 to address 0 bit 1 sets both counters to zero in the next cycle. The bit reads back as 0, and bit 0 takes the written enable value.
- R8: Each counter is CNT_W bits wide, zero-extended on read, and holds at its all-ones value instead of wrapping.
- R9: Every counted frame boundary latches the finished checksum into the last-checksum register (address 4).
- R10: After reset, every register reads 0.
- R11: Pixels on consecutive clock cycles with data-enable held high are all included in the checksum, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| pix_data | input | PIX_W | Pixel, R in the top byte, B in the bottom byte |
| pix_de | input | 1 | High when pix_data carries an active pixel |
| pix_vsync | input | 1 | Vertical sync; its rising edge is the frame boundary |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The bench builds the checker with PIX_W=24 and CNT_W=4. With four-bit counters, seventeen matching frames are enough to reach the saturation point, so the hold-at-maximum behaviour is exercised without running thousands of frames. The 24-bit pixel width keeps the R-G-B byte order visible, so a fixed check vector with a known checksum can be used to test it.

// File: rtl/vfcrc_pkg.sv
package vfcrc_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_REF  = 3'd1,
    REG_GOOD = 3'd2,
    REG_BAD  = 3'd3,
    REG_LAST = 3'd4
  } reg_addr_e;

  // One byte through the reflected CRC32, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] crc_in,
                                           input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/vfcrc_engine.sv
module vfcrc_engine
  import vfcrc_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix,
  output logic [31:0]      crc_raw
);

  localparam int unsigned BYTES = PIX_W / 8;

  logic [31:0] crc_q, crc_n;
  logic [31:0] chain [0:BYTES];

  assign chain[0] = crc_q;

  // The most significant byte (R) is folded in first.
  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
      assign chain[g+1] = crc_byte(chain[g], pix[PIX_W-1-8*g -: 8]);
    end
  endgenerate

  always_comb begin
    crc_n = crc_q;
    if (restart)      crc_n = CRC_INIT;
    else if (pix_vld) crc_n = chain[BYTES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_n;
  end

  assign crc_raw = crc_q;

  assert_restart_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> crc_raw == CRC_INIT);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !pix_vld) |=> $stable(crc_raw));

endmodule

// File: rtl/vfcrc_frame_ctl.sv
module vfcrc_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vsync,
  input  logic de,
  output logic frame_start,
  output logic pix_vld,
  output logic close_ev
);

  logic vs_q,    vs_n;
  logic armed_q, armed_n;
  logic seen_q,  seen_n;
  logic vs_rise;

  assign vs_rise = vsync & ~vs_q;

  always_comb begin
    vs_n    = vsync;
    armed_n = en ? (armed_q | vs_rise) : 1'b0;
    seen_n  = seen_q;
    if (!en)          seen_n = 1'b0;
    else if (vs_rise) seen_n = 1'b0;
    else if (de)      seen_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      vs_q    <= vs_n;
      armed_q <= armed_n;
      seen_q  <= seen_n;
    end
  end

  assign frame_start = vs_rise;
  assign pix_vld     = en & de & ~vs_rise;
  assign close_ev    = en & armed_q & vs_rise & seen_q;

  assert_arm_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(vsync) && !$past(vs_q));

  assert_seen_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> !seen_q);

endmodule

// File: rtl/vfcrc_sat_counter.sv
module vfcrc_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                       cnt_n = '0;
    else if (inc && cnt_q != MAXV) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/vfcrc_checker.sv
module vfcrc_checker
  import vfcrc_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIX_W-1:0]    pix_data,
  input  logic                pix_de,
  input  logic                pix_vsync,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata
);

  logic        en_q,   en_n;
  logic [31:0] ref_q,  ref_n;
  logic [31:0] last_q, last_n;
  logic        clr_pulse;

  logic        frame_start, pix_vld, close_ev;
  logic [31:0] crc_raw, crc_fin;
  logic        match, good_inc, bad_inc;
  logic [CNT_W-1:0] good_cnt, bad_cnt;

  logic wr_ctrl, wr_ref;
  assign wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
  assign wr_ref    = reg_wr && (reg_addr == REG_REF);
  assign clr_pulse = wr_ctrl && reg_wdata[1];

  vfcrc_frame_ctl u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_q),
    .vsync       (pix_vsync),
    .de          (pix_de),
    .frame_start (frame_start),
    .pix_vld     (pix_vld),
    .close_ev    (close_ev)
  );

  vfcrc_engine #(.PIX_W(PIX_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_start),
    .pix_vld (pix_vld),
    .pix     (pix_data),
    .crc_raw (crc_raw)
  );

  assign crc_fin  = ~crc_raw;
  assign match    = (crc_fin == ref_q);
  assign good_inc = close_ev & match;
  assign bad_inc  = close_ev & ~match;

  vfcrc_sat_counter #(.W(CNT_W)) u_good (
    .clk (clk), .rst_n (rst_n), .clr (clr_pulse), .inc (good_inc), .cnt (good_cnt)
  );

  vfcrc_sat_counter #(.W(CNT_W)) u_bad (
    .clk (clk), .rst_n (rst_n), .clr (clr_pulse), .inc (bad_inc), .cnt (bad_cnt)
  );

  always_comb begin
    en_n   = wr_ctrl  ? reg_wdata[0] : en_q;
    ref_n  = wr_ref   ? reg_wdata    : ref_q;
    last_n = close_ev ? crc_fin      : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ref_q  <= '0;
      last_q <= '0;
    end else begin
      en_q   <= en_n;
      ref_q  <= ref_n;
      last_q <= last_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: reg_rdata = {31'd0, en_q};
      REG_REF:  reg_rdata = ref_q;
      REG_GOOD: reg_rdata = 32'(good_cnt);
      REG_BAD:  reg_rdata = 32'(bad_cnt);
      REG_LAST: reg_rdata = last_q;
      default:  reg_rdata = '0;
    endcase
  end

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (good_cnt == '0) && (bad_cnt == '0));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_pulse) |=> $stable(good_cnt) && $stable(bad_cnt) && $stable(last_q));

  assert_single_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> ($countones({good_cnt != $past(good_cnt), bad_cnt != $past(bad_cnt)}) <= 1));

endmodule

// File: tb/vfcrc_checker_bench.sv
module vfcrc_checker_bench;

  localparam int PIX_W = 24;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [PIX_W-1:0] pix_data;
  logic             pix_de;
  logic             pix_vsync;
  logic             reg_wr;
  logic [2:0]       reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vfcrc_checker #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_vfcrc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_data  (pix_data),
    .pix_de    (pix_de),
    .pix_vsync (pix_vsync),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  function automatic logic [23:0] pix_of(int i, int seed);
    if (seed == 0) return {8'(8'h31 + 3*i), 8'(8'h32 + 3*i), 8'(8'h33 + 3*i)};
    return {8'(i*7 + seed), 8'(i*13 + 5), 8'(i ^ seed)};
  endfunction

  function automatic logic [31:0] model_crc(int n, int seed);
    logic [31:0] c;
    logic [23:0] p;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      p = pix_of(i, seed);
      for (int k = 0; k < 3; k++) begin
        c = c ^ {24'd0, p[23-8*k -: 8]};
        for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic vs_pulse();
    @(negedge clk); pix_vsync = 1'b1;
    @(negedge clk);
    @(negedge clk); pix_vsync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_pixels(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_de = 1'b1; pix_data = pix_of(i, seed);
    end
    @(negedge clk);
    pix_de = 1'b0; pix_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R10 reset value", v, 32'd0);
    end
  endtask

  task automatic t_first_and_match();
    logic [31:0] v;
    wr(3'd1, 32'hCBF4_3926);
    wr(3'd0, 32'd1);
    send_pixels(5, 9);            // partial frame before arming
    vs_pulse();                   // arms only
    rd(3'd2, v); chk("R4 discard good", v, 0);
    rd(3'd3, v); chk("R4 discard bad", v, 0);
    rd(3'd4, v); chk("R4 last untouched", v, 0);
    send_pixels(3, 0);            // "123456789", back to back (R11)
    vs_pulse();
    rd(3'd2, v); chk("R2 good after match", v, 1);
    rd(3'd3, v); chk("R2 bad unchanged", v, 0);
    rd(3'd4, v); chk("R1 check vector crc", v, 32'hCBF4_3926);
  endtask

  task automatic t_mismatch();
    logic [31:0] v;
    send_pixels(50, 77);
    vs_pulse();
    rd(3'd3, v); chk("R3 bad after mismatch", v, 1);
    rd(3'd2, v); chk("R3 good unchanged", v, 1);
    rd(3'd4, v); chk("R9 last crc latched", v, model_crc(50, 77));
  endtask

  task automatic t_empty();
    logic [31:0] v;
    vs_pulse();
    rd(3'd2, v); chk("R5 empty good", v, 1);
    rd(3'd3, v); chk("R5 empty bad", v, 1);
    rd(3'd4, v); chk("R5 empty last", v, model_crc(50, 77));
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(3'd0, 32'd0);
    rd(3'd0, v); chk("R6 enable reads 0", v, 0);
    send_pixels(3, 0); vs_pulse();
    send_pixels(8, 5); vs_pulse();
    rd(3'd2, v); chk("R6 good held", v, 1);
    rd(3'd3, v); chk("R6 bad held", v, 1);
    rd(3'd4, v); chk("R6 last held", v, model_crc(50, 77));
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, 32'd2);
    rd(3'd2, v); chk("R7 good cleared", v, 0);
    rd(3'd3, v); chk("R7 bad cleared", v, 0);
    rd(3'd0, v); chk("R7 ctrl readback", v, 0);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    wr(3'd1, model_crc(20, 3));
    wr(3'd0, 32'd1);
    rd(3'd0, v); chk("R7 enable readback", v, 1);
    vs_pulse();
    for (int f = 0; f < 17; f++) begin
      send_pixels(20, 3);
      vs_pulse();
    end
    rd(3'd2, v); chk("R8 good saturates", v, 15);
    rd(3'd3, v); chk("R8 bad stays zero", v, 0);
    rd(3'd4, v); chk("R1 model crc", v, model_crc(20, 3));
  endtask

  initial begin
    rst_n = 1'b0; pix_data = '0; pix_de = 1'b0; pix_vsync = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_and_match();
    t_mismatch();
    t_empty();
    t_disabled();
    t_clear();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule